// File: doc/BRIEF.md
# Synchronous Burst SRAM with Selectable Read Latency

This block is a synthesizable synchronous static memory with a built-in two-bit burst address sequencer. On every rising clock edge it samples an address, a write word, three chip enables, two address-load strobes, a burst-advance input and the write controls. A load strobe while the chip is selected opens a burst at the presented address. The cycles that follow, with no strobe, continue that burst. They either advance the low two address bits in linear or interleaved order, or hold them so that the same location is accessed again. A load strobe while the chip is not selected is a deselect, which closes the burst.

Writes can store the whole word or any subset of its four 9-bit lanes. Reads come out in one of two ways, chosen by a static mode input. In flow-through mode the array output reaches the data pins in the cycle right after the capturing edge. In pipelined mode the data passes through one more rising-edge register. The bus-drive flag follows the read pipeline, so a deselect turns the outputs off without an extra trailing cycle. Output enable and a sleep input gate the drive without waiting for a clock. While sleep is sampled high, the block ignores every access and keeps its contents.

The access controller is a three-state machine: `ST_IDLE` (no burst open), `ST_BURST` (burst open) and `ST_SLEEP` (sleeping). Its transitions are:
- *open*: from `ST_IDLE` or `ST_SLEEP` to `ST_BURST`, on a selected strobe.
- *reload*: from `ST_BURST` to `ST_BURST`, on a selected strobe.
- *continue*: from `ST_BURST` to `ST_BURST`, when there is no strobe.
- *close*: from any state to `ST_IDLE`, on an unselected strobe.
- *doze*: from any state to `ST_SLEEP`, when sleep is sampled high.
- *wake*: from `ST_SLEEP` to `ST_IDLE`, when sleep is low and there is no strobe.

Top module: `sburst_sram`

## Requirements
- R1: The chip counts as selected only when en1_n_i=0, en2_i=1 and en3_n_i=0 at an edge where a load strobe is low. A strobe with any other enable combination performs no access and closes the burst, so the next cycle without a strobe accesses nothing.
- R2: With flow_i=1, the word read by an access captured at edge n is on rdata_o, with drive_o high, in the cycle right after edge n. Back-to-back strobes give one word per cycle.
- R3: With flow_i=0, the word read at edge n appears in the cycle after edge n+1, and a new access may be captured on every edge.
- R4: A write with allwr_n_i=0 stores all four lanes, whatever lane_n_i and bwr_n_i are. Lane i occupies bits [9i+8:9i].
- R5: A write with allwr_n_i=1 and bwr_n_i=0 stores only the lanes whose lane_n_i bit is 0. The other lanes keep their contents.
- R6: Inside a burst, adv_n_i=0 advances a 2-bit count. The low two address bits are start XOR count when linear_i=0, and (start+count) mod 4 when linear_i=1. With adv_n_i=1 the same address is accessed again.
- R7: A selected ld_rd_n_i=0 always starts a read and ignores the write controls, and it wins over ld_n_i. A selected ld_n_i=0 alone starts a write when allwr_n_i or bwr_n_i is low, and a read otherwise.
- R8: After a deselect captured at edge d, drive_o is low in the cycle after edge d in flow-through mode. In pipelined mode it is low in the cycle after edge d+1, and the only word still driven after edge d is a read captured at edge d-1.
- R9: drive_o is high only while oe_n_i=0, sleep_i=0 and a read word is due. oe_n_i and sleep_i act at once, without a clock edge.
- R10: An edge that samples sleep_i=1 ignores all reads and writes and closes the burst. Stored data is kept through sleep.
- R11: During reset and after it, drive_o is low and no burst is open.
- R12: With flow_i=0 and linear_i=0, the memory gives interleaved burst order with pipelined latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Address sampled on a load strobe |
| wdata_i | input | 36 | Write word, four 9-bit lanes |
| en1_n_i | input | 1 | Chip enable, active low |
| en2_i | input | 1 | Chip enable, active high |
| en3_n_i | input | 1 | Chip enable, active low |
| ld_rd_n_i | input | 1 | Load strobe that always reads, active low |
| ld_n_i | input | 1 | Load strobe for a read or a write, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| allwr_n_i | input | 1 | Whole-word write, active low |
| bwr_n_i | input | 1 | Lane write enable, active low |
| lane_n_i | input | 4 | Per-lane selects, active low |
| oe_n_i | input | 1 | Output enable, asynchronous, active low |
| sleep_i | input | 1 | Sleep request, active high |
| flow_i | input | 1 | 1 selects flow-through reads, 0 selects pipelined reads |
| linear_i | input | 1 | 1 selects linear burst order, 0 selects interleaved order |
| rdata_o | output | 36 | Read word |
| drive_o | output | 1 | Data bus drive; low means high impedance |

## Verification
A read captured at edge n is due in the cycle after edge n in flow-through mode, and in the cycle after edge n+1 in pipelined mode. A write or deselect is due as an "undriven" cycle at the same offset. The driver stamps every expected item with the edge number at which it falls due. The monitor samples at the falling edge and compares only items whose stamp matches the current edge count, so any word that arrives early or late is a mismatch. The bench changes output enable and sleep between edges, and applies them to the expected drive at sampling time, because they act without a clock. The mode inputs change only after idle cycles have drained the pipeline.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    parameter int unsigned SBS_BURST_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_SLEEP = 2'd2
    } sbs_state_e;
endpackage

// File: rtl/sbs_burst_ctr.sv
// Two-bit burst sequencer: yields the low address bits of the current cycle.
module sbs_burst_ctr #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          adv_i,
    input  logic          linear_i,
    input  logic [CW-1:0] start_i,
    output logic [CW-1:0] idx_o
);
    logic [CW-1:0] base_q, cnt_q, base_d, cnt_d;

    always_comb begin
        base_d = load_i ? start_i : base_q;
        if (load_i)
            cnt_d = '0;
        else if (adv_i)
            cnt_d = cnt_q + CW'(1);
        else
            cnt_d = cnt_q;
    end

    // linear order adds the count, interleaved order flips bits with it
    assign idx_o = linear_i ? (base_d + cnt_d) : (base_d ^ cnt_d);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/sbs_lane_mem.sv
// Storage split per lane; each lane has its own write strobe.
module sbs_lane_mem #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DATA_W = LANES * LANE_W,
    localparam int unsigned DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i[l])
                cells[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
        end

        assign rdata_o[l*LANE_W +: LANE_W] = cells[raddr_i];
    end
endmodule

// File: rtl/sbs_out_path.sv
// Output stage: flow-through bypass or one extra register, plus drive gating.
module sbs_out_path #(
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_i,
    input  logic              rd_vld_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              oe_n_i,
    input  logic              sleep_i,
    output logic [DATA_W-1:0] data_o,
    output logic              drive_o
);
    logic              s2_vld;
    logic [DATA_W-1:0] s2_data;
    logic              word_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s2_vld <= 1'b0;
        else
            s2_vld <= rd_vld_i;
    end

    always_ff @(posedge clk) begin
        s2_data <= rd_data_i;
    end

    assign word_vld = flow_i ? rd_vld_i : s2_vld;
    assign data_o   = flow_i ? rd_data_i : s2_data;
    assign drive_o  = word_vld & ~oe_n_i & ~sleep_i;
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
    import sbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              en1_n_i,
    input  logic              en2_i,
    input  logic              en3_n_i,
    input  logic              ld_rd_n_i,
    input  logic              ld_n_i,
    input  logic              adv_n_i,
    input  logic              allwr_n_i,
    input  logic              bwr_n_i,
    input  logic [LANES-1:0]  lane_n_i,
    input  logic              oe_n_i,
    input  logic              sleep_i,
    input  logic              flow_i,
    input  logic              linear_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              drive_o
);
    localparam int unsigned HI_W = ADDR_W - SBS_BURST_W;

    sbs_state_e st_q, st_d;
    logic chip_sel, wr_req, strobe;
    logic ld, adv, acc_rd, acc_wr;
    logic [LANES-1:0]       lane_we;
    logic [SBS_BURST_W-1:0] idx;
    logic [HI_W-1:0]        hi_q;
    logic [ADDR_W-1:0]      cyc_addr, s1_addr;
    logic                   s1_rd;
    logic [DATA_W-1:0]      arr_rd;

    assign chip_sel = ~en1_n_i & en2_i & ~en3_n_i;
    assign wr_req   = ~allwr_n_i | ~bwr_n_i;
    assign strobe   = ~ld_rd_n_i | ~ld_n_i;

    // decode and next state
    always_comb begin
        st_d   = st_q;
        ld     = 1'b0;
        adv    = 1'b0;
        acc_rd = 1'b0;
        acc_wr = 1'b0;
        if (sleep_i) begin
            st_d = ST_SLEEP;
        end else if (strobe) begin
            if (chip_sel) begin
                ld     = 1'b1;
                acc_rd = ~ld_rd_n_i | ~wr_req;
                acc_wr = ~acc_rd;
                st_d   = ST_BURST;
            end else begin
                st_d = ST_IDLE;
            end
        end else begin
            unique case (st_q)
                ST_BURST: begin
                    adv    = ~adv_n_i;
                    acc_rd = ~wr_req;
                    acc_wr = wr_req;
                end
                ST_IDLE, ST_SLEEP: st_d = ST_IDLE;
                default:           st_d = ST_IDLE;
            endcase
        end
        lane_we = '0;
        if (acc_wr)
            lane_we = ~allwr_n_i ? '1 : ~lane_n_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // input register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            s1_rd   <= 1'b0;
            s1_addr <= '0;
        end else begin
            if (ld)
                hi_q <= addr_i[ADDR_W-1:SBS_BURST_W];
            s1_rd <= acc_rd;
            if (acc_rd)
                s1_addr <= cyc_addr;
        end
    end

    assign cyc_addr = ld ? addr_i : {hi_q, idx};

    sbs_burst_ctr #(.CW(SBS_BURST_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (ld),
        .adv_i    (adv),
        .linear_i (linear_i),
        .start_i  (addr_i[SBS_BURST_W-1:0]),
        .idx_o    (idx)
    );

    sbs_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .we_i    (lane_we),
        .waddr_i (cyc_addr),
        .wdata_i (wdata_i),
        .raddr_i (s1_addr),
        .rdata_o (arr_rd)
    );

    sbs_out_path #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_i    (flow_i),
        .rd_vld_i  (s1_rd),
        .rd_data_i (arr_rd),
        .oe_n_i    (oe_n_i),
        .sleep_i   (sleep_i),
        .data_o    (rdata_o),
        .drive_o   (drive_o)
    );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int unsigned LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flow_i,
    input logic             oe_n_i,
    input logic             sleep_i,
    input logic             ld_rd_n_i,
    input logic             ld_n_i,
    input logic             en1_n_i,
    input logic             en2_i,
    input logic             en3_n_i,
    input logic             acc_rd,
    input logic             acc_wr,
    input logic [LANES-1:0] lane_we,
    input logic             drive_o
);
    logic strobe_seen, desel_in;
    assign strobe_seen = ~ld_rd_n_i | ~ld_n_i;
    assign desel_in    = ~sleep_i & strobe_seen & ~(~en1_n_i & en2_i & ~en3_n_i);

    // R2: a flow-through read drives in the very next cycle
    a_r2_flow_word_due: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_i && acc_rd) |=> (drive_o || oe_n_i || sleep_i || !flow_i));

    // R3: a pipelined read drives one cycle later
    a_r3_pipe_word_due: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_i && acc_rd) |=> ##1 (drive_o || oe_n_i || sleep_i || flow_i));

    // R8: deselect turns the bus off after one stage in flow-through mode
    a_r8_flow_off: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_i && desel_in) |=> (!drive_o || !flow_i));

    // R8: and after two stages in pipelined mode
    a_r8_pipe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_i && desel_in) |=> ##1 (!drive_o || flow_i));

    // R10: no lane is written while asleep
    a_r10_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> (lane_we == '0));

    // R1: an unselected strobe reaches neither the array nor the read path
    a_r1_unselected_idle: assert property (@(posedge clk) disable iff (!rst_n)
        desel_in |-> (!acc_rd && !acc_wr));

    // R7: the read-only strobe never writes
    a_r7_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_rd_n_i && !sleep_i) |-> !acc_wr);
endmodule

bind sburst_sram sbs_checker #(.LANES(LANES)) u_sbs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flow_i    (flow_i),
    .oe_n_i    (oe_n_i),
    .sleep_i   (sleep_i),
    .ld_rd_n_i (ld_rd_n_i),
    .ld_n_i    (ld_n_i),
    .en1_n_i   (en1_n_i),
    .en2_i     (en2_i),
    .en3_n_i   (en3_n_i),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .lane_we   (lane_we),
    .drive_o   (drive_o)
);

// File: tb/sburst_sram_bench.sv
`timescale 1ns/1ps
module sburst_sram_bench;
    localparam int AW = 6;
    localparam int DW = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr_b = '0;
    logic [DW-1:0] wdata_b = '0;
    logic e1n_b = 1'b1, e2_b = 1'b0, e3n_b = 1'b1;
    logic ldr_n_b = 1'b1, ld_n_b = 1'b1, adv_n_b = 1'b1;
    logic gw_n_b = 1'b1, bw_n_b = 1'b1;
    logic [3:0] ln_b = 4'hF;
    logic oe_n_b = 1'b0, sleep_b = 1'b0, flow_b = 1'b0, linear_b = 1'b0;
    logic [DW-1:0] rdata;
    logic drive;

    always #2.5 clk = ~clk;

    sburst_sram u_sburst_sram (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_b), .wdata_i(wdata_b),
        .en1_n_i(e1n_b), .en2_i(e2_b), .en3_n_i(e3n_b),
        .ld_rd_n_i(ldr_n_b), .ld_n_i(ld_n_b), .adv_n_i(adv_n_b),
        .allwr_n_i(gw_n_b), .bwr_n_i(bw_n_b), .lane_n_i(ln_b),
        .oe_n_i(oe_n_b), .sleep_i(sleep_b), .flow_i(flow_b), .linear_i(linear_b),
        .rdata_o(rdata), .drive_o(drive)
    );

    int ecount = 0;
    int checks = 0;
    int fails = 0;
    bit mon_on = 1'b0;
    always @(posedge clk) ecount <= ecount + 1;

    // scoreboard queues
    int            q_due[$];
    bit            q_vld[$];
    logic [DW-1:0] q_dat[$];
    string         q_tag[$];

    // reference state
    logic [DW-1:0] ref_mem [64];
    bit            open_m = 1'b0;
    logic [AW-1:0] base_m = '0;
    logic [1:0]    cnt_m = '0;

    function automatic logic [DW-1:0] mkw(input int s);
        return {9'(s*7+3), 9'(s*5+2), 9'(s*3+1), 9'(s)};
    endfunction

    task automatic chk(input string tag, input bit ok, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at edge %0d", tag, act, exp, ecount);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // driver: one clock cycle per call, inputs change 1 ns after the edge
    task automatic cyc(input string tag, input bit ldr_n, input bit ld_n,
                       input bit e1n, input bit e2, input bit e3n, input bit av_n,
                       input bit gw_n, input bit bw_n, input logic [3:0] ln,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        int edge_no;
        bit sel, wreq, rd, wr;
        logic [AW-1:0] ea;
        edge_no = ecount + 1;
        ldr_n_b = ldr_n; ld_n_b = ld_n; e1n_b = e1n; e2_b = e2; e3n_b = e3n;
        adv_n_b = av_n; gw_n_b = gw_n; bw_n_b = bw_n; ln_b = ln; addr_b = a; wdata_b = d;
        sel = !e1n && e2 && !e3n;
        wreq = !gw_n || !bw_n;
        rd = 1'b0; wr = 1'b0; ea = '0;
        if (sleep_b) begin
            open_m = 1'b0;
        end else if (!ldr_n || !ld_n) begin
            if (sel) begin
                base_m = a; cnt_m = 2'd0; open_m = 1'b1; ea = a;
                rd = !ldr_n || !wreq; wr = !rd;
            end else begin
                open_m = 1'b0;
            end
        end else if (open_m) begin
            if (!av_n) cnt_m = cnt_m + 2'd1;
            ea = {base_m[AW-1:2], linear_b ? 2'(base_m[1:0] + cnt_m) : (base_m[1:0] ^ cnt_m)};
            rd = !wreq; wr = wreq;
        end
        q_due.push_back(edge_no + (flow_b ? 0 : 1));
        q_vld.push_back(rd);
        q_dat.push_back(rd ? ref_mem[ea] : '0);
        q_tag.push_back(tag);
        if (wr) begin
            for (int l = 0; l < 4; l++)
                if (!gw_n || !ln[l]) ref_mem[ea][l*9 +: 9] = d[l*9 +: 9];
        end
        @(posedge clk);
        #1;
    endtask

    task automatic rd_go(input string t, input logic [AW-1:0] a);
        cyc(t, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, a, '0);
    endtask
    task automatic ldc(input string t, input logic [AW-1:0] a, input bit gw_n, input bit bw_n,
                       input logic [3:0] ln, input logic [DW-1:0] d);
        cyc(t, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, gw_n, bw_n, ln, a, d);
    endtask
    task automatic nxt_rd(input string t, input bit adv);
        cyc(t, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, !adv, 1'b1, 1'b1, 4'hF, '0, '0);
    endtask
    task automatic nxt_wr(input string t, input logic [DW-1:0] d);
        cyc(t, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, '0, d);
    endtask
    task automatic dsl(input string t);
        cyc(t, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, '0, '0);
    endtask
    task automatic idle(input string t);
        cyc(t, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, '0, '0);
    endtask

    // monitor: mid-cycle comparison of items due at the current edge
    initial begin
        wait (mon_on);
        forever begin
            @(negedge clk);
            while (q_due.size() > 0 && q_due[0] <= ecount) begin
                bit exp_drv;
                exp_drv = q_vld[0] && !oe_n_b && !sleep_b;
                if (q_due[0] < ecount)
                    chk({q_tag[0], " missed"}, 1'b0, '0, q_dat[0]);
                else begin
                    chk({q_tag[0], " drive"}, drive == exp_drv, DW'(drive), DW'(exp_drv));
                    if (exp_drv)
                        chk({q_tag[0], " data"}, rdata == q_dat[0], rdata, q_dat[0]);
                end
                void'(q_due.pop_front()); void'(q_vld.pop_front());
                void'(q_dat.pop_front()); void'(q_tag.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R11: no drive while in reset even with output enable low
        chk("R11 reset", drive == 1'b0, DW'(drive), '0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle("R11 after reset");

        // R4 whole-word write burst, interleaved order from 5: 5,4,7,6
        ldc("R4", 6'h05, 1'b0, 1'b1, 4'hF, mkw(1));
        nxt_wr("R6", mkw(2));
        nxt_wr("R6", mkw(3));
        nxt_wr("R6", mkw(4));
        // R12 default modes: pipelined, interleaved
        rd_go("R12", 6'h05);
        nxt_rd("R12", 1'b1);
        nxt_rd("R12", 1'b1);
        nxt_rd("R3", 1'b1);
        dsl("R8 pipe");
        idle("R8 pipe");
        idle("R11");

        // R6 linear order from 6: 6,7,4,5 then hold
        linear_b = 1'b1;
        rd_go("R6 linear", 6'h06);
        nxt_rd("R6 linear", 1'b1);
        nxt_rd("R6 linear", 1'b1);
        nxt_rd("R6 linear", 1'b1);
        nxt_rd("R6 hold", 1'b0);
        dsl("R8");
        idle("R8");
        linear_b = 1'b0;

        // R5 lane writes: lanes 1 and 3 only
        ldc("R5", 6'h04, 1'b1, 1'b0, 4'b0101, mkw(9));
        dsl("R5");
        rd_go("R5", 6'h04);
        // R4 global write wins over empty lane selects
        ldc("R4", 6'h07, 1'b0, 1'b0, 4'hF, mkw(11));
        rd_go("R4", 6'h07);

        // R7 read-only strobe ignores write controls and beats the other strobe
        cyc("R7", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 6'h06, mkw(30));
        cyc("R7", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 6'h06, mkw(31));
        ldc("R7 ld read", 6'h06, 1'b1, 1'b1, 4'hF, '0);
        dsl("R7");

        // R1 unselected strobes: no write, no read, burst closed
        cyc("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h06, mkw(40));
        cyc("R1", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'h06, '0);
        rd_go("R1", 6'h04);
        cyc("R1 close", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h04, '0);
        nxt_rd("R1 closed", 1'b1);
        rd_go("R1", 6'h06);
        dsl("R1");
        idle("R1");

        // R9 output enable gates a due word without a clock
        rd_go("R9", 6'h05);
        dsl("R9");
        oe_n_b = 1'b1;
        idle("R9");
        oe_n_b = 1'b0;
        idle("R9");

        // R2 flow-through, new address every cycle
        flow_b = 1'b1;
        idle("R2");
        rd_go("R2", 6'h04);
        rd_go("R2", 6'h05);
        rd_go("R2", 6'h06);
        nxt_rd("R2", 1'b1);
        dsl("R8 flow");
        idle("R8 flow");

        // R10 sleep ignores accesses and keeps data
        ldc("R10", 6'h10, 1'b0, 1'b1, 4'hF, mkw(50));
        dsl("R10");
        sleep_b = 1'b1;
        ldc("R10 sleep", 6'h10, 1'b0, 1'b1, 4'hF, mkw(60));
        rd_go("R10 sleep", 6'h10);
        sleep_b = 1'b0;
        idle("R10");
        rd_go("R10 wake", 6'h10);
        dsl("R10");
        idle("R10");

        flow_b = 1'b0;
        idle("R3");
        idle("R3");
        idle("R3");
        repeat (3) @(posedge clk);
        #1;
        chk("R11 drained", q_due.size() == 0, DW'(q_due.size()), '0);
        finish_up();
    end
endmodule